// File: doc/BRIEF.md
# Shared Round-Key Bank for AES-128

This block takes one 128-bit cipher key and, on request, derives the complete AES-128 key schedule: the original key plus ten further 128-bit round keys, eleven in all. It works out one 32-bit schedule word per clock and writes each word into an internal register table. That table feeds several independent read ports. A cluster of encryption and decryption engines can therefore share one expander, and each engine looks up any round key by its number without generating keys itself.

A one-cycle pulse on `start` captures `key_in` and begins the expansion. `ready` stays low during the expansion and rises a fixed 45 cycles after the start edge. From then on, every read port returns the round key that its index selects. The table then stays unchanged until the next `start`. A read port returns zero while the schedule is incomplete, and also for an index that names no round key.

Top module: `round_key_bank`

## Requirements
- R1: After reset, `ready` is low and every read port outputs zero.
- R2: When `start` is high at a rising clock edge, `key_in` is captured at that edge. Round key 0 equals that captured key.
- R3: If `start` is high at clock edge k and low afterwards, `ready` is low after edges k through k+44 and high after edge k+45.
- R4: Schedule word i, for i from 4 to 43, equals word i-4 XOR word i-1. When i is a multiple of 4, word i-1 is first rotated left by one byte, then passed through the AES S-box byte by byte, and its top byte is XORed with a round constant. Round key r is words 4r to 4r+3, with word 4r in bits 127:96.
- R5: The round constants used for words 4, 8, …, 40 are 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36, in that order. As a result, round keys 1 and 10 match the published AES-128 examples.
- R6: Each read port p drives `rd_key[128p+127:128p]` from its own 4-bit index `rd_idx[4p+3:4p]`, combinationally and independently of the other ports.
- R7: While `ready` is low, every read port outputs zero.
- R8: An index from 11 to 15 reads as zero, even when `ready` is high.
- R9: A `start` that arrives during an expansion abandons that expansion and begins again with the newly captured key. `ready` then rises 45 edges after the latest start.
- R10: Once `ready` is high, changes on `key_in` without `start` leave every round key unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture key_in and begin expansion |
| key_in | input | 128 | Cipher key |
| rd_idx | input | 4*NPORTS | Round index for each read port |
| rd_key | output | 128*NPORTS | Round key for each read port |
| ready | output | 1 | Full schedule valid |

## Verification
The expansion is run on three keys: the published example key, an all-zero key and a counting byte key. These three separate the rotate, S-box and round-constant paths. The all-zero key makes round 1 depend only on the S-box of zero and on the first constant. The other two keys spread errors across all bytes and reach the late constants 1B and 36. A restart in mid-expansion shows whether stale words or a stale counter survive. Index values beyond 10, reads before `ready`, and key changes without `start` exercise the gating and hold behaviour.

// File: rtl/rkb_pkg.sv
package rkb_pkg;
    localparam int WORD_W  = 32;
    localparam int KEY_W   = 128;
    localparam int NRKEYS  = 11;
    localparam int NWORDS  = 4 * NRKEYS;
    localparam int IDX_W   = 4;
    localparam int WIDX_W  = $clog2(NWORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  rkey_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} gen_state_e;

    // Write request from the word generator to the table
    typedef struct packed {
        logic              load;   // write captured key as round 0
        rkey_t             key;
        logic              we;     // write one schedule word
        logic [WIDX_W-1:0] widx;
        word_t             wdata;
    } tbl_wr_t;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] p = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r = 8'h01;
        logic [7:0] p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // Round constant for round n (1..10)
    function automatic logic [7:0] rcon(input logic [3:0] n);
        logic [7:0] r = 8'h01;
        for (int i = 1; i < 10; i++)
            if (i < int'(n)) r = xtime(r);
        return r;
    endfunction
endpackage

// File: rtl/rkb_word_gen.sv
module rkb_word_gen
    import rkb_pkg::*;
#(
    parameter int LATENCY = 45
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  rkey_t   key_in,
    output tbl_wr_t wr,
    output logic    ready
);
    localparam int CNT_W  = $clog2(LATENCY + 1);
    localparam int NGEN   = NWORDS - 4;

    gen_state_e        state;
    logic [CNT_W-1:0]  cnt;
    rkey_t             win;      // last four words, oldest in 127:96
    word_t             newest, oldest, rotw, subw, tmp, nxt;
    logic              gen_now;
    logic [3:0]        rnd;

    always_comb begin
        oldest  = win[127:96];
        newest  = win[31:0];
        gen_now = (state == ST_RUN) && (cnt < CNT_W'(NGEN));
        rnd     = 4'(cnt >> 2) + 4'd1;
        rotw    = {newest[23:0], newest[31:24]};
        for (int b = 0; b < 4; b++)
            subw[b*8 +: 8] = sbox(rotw[b*8 +: 8]);
        tmp     = (cnt[1:0] == 2'b00) ? (subw ^ {rcon(rnd), 24'h0}) : newest;
        nxt     = oldest ^ tmp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            win   <= '0;
        end else if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
            win   <= key_in;
        end else if (state == ST_RUN) begin
            cnt <= cnt + 1'b1;
            if (gen_now) win <= {win[95:0], nxt};
            if (cnt == CNT_W'(LATENCY - 1)) state <= ST_DONE;
        end
    end

    always_comb begin
        wr.load  = start;
        wr.key   = key_in;
        wr.we    = gen_now && !start;
        wr.widx  = WIDX_W'(cnt) + WIDX_W'(4);
        wr.wdata = nxt;
    end

    assign ready = (state == ST_DONE);

    // R9: a start always removes the valid flag on the next cycle
    a_r9_start_drops_ready: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);
    // R3: the valid flag only appears after a running expansion
    a_r3_ready_follows_run: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(state) == ST_RUN);
    // R4: words are written only while an expansion runs and never past the table
    a_r4_write_window: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> (state == ST_RUN) && (wr.widx < WIDX_W'(NWORDS)) && !ready);
endmodule

// File: rtl/rkb_table.sv
module rkb_table
    import rkb_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  tbl_wr_t                   wr,
    input  logic                      ready,
    input  logic [NPORTS*IDX_W-1:0]   rd_idx,
    output logic [NPORTS*KEY_W-1:0]   rd_key
);
    rkey_t mem [NRKEYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NRKEYS; r++) mem[r] <= '0;
        end else if (wr.load) begin
            mem[0] <= wr.key;
        end else if (wr.we) begin
            mem[wr.widx[WIDX_W-1:2]][(3 - int'(wr.widx[1:0])) * WORD_W +: WORD_W] <= wr.wdata;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [IDX_W-1:0] idx;
        assign idx = rd_idx[p*IDX_W +: IDX_W];
        assign rd_key[p*KEY_W +: KEY_W] =
            (ready && (idx < IDX_W'(NRKEYS))) ? mem[idx] : '0;

        // R7: nothing leaves a port before the schedule is complete
        a_r7_gated: assert property (@(posedge clk) disable iff (rst)
            !ready |-> rd_key[p*KEY_W +: KEY_W] == '0);
        // R8: indices past the last round read as zero
        a_r8_range: assert property (@(posedge clk) disable iff (rst)
            (idx >= IDX_W'(NRKEYS)) |-> rd_key[p*KEY_W +: KEY_W] == '0);
        // R10: a valid table holds still for a steady index
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            ready && $past(ready) && $stable(idx) |-> $stable(rd_key[p*KEY_W +: KEY_W]));
    end
endmodule

// File: rtl/round_key_bank.sv
module round_key_bank
    import rkb_pkg::*;
#(
    parameter int NPORTS  = 4,
    parameter int LATENCY = 45
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [127:0]            key_in,
    input  logic [NPORTS*4-1:0]     rd_idx,
    output logic [NPORTS*128-1:0]   rd_key,
    output logic                    ready
);
    tbl_wr_t wr;

    rkb_word_gen #(.LATENCY(LATENCY)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .key_in (key_in),
        .wr     (wr),
        .ready  (ready)
    );

    rkb_table #(.NPORTS(NPORTS)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .ready  (ready),
        .rd_idx (rd_idx),
        .rd_key (rd_key)
    );

    // R1: reset leaves the bank empty
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !ready && rd_key == '0);
endmodule

// File: tb/sim_round_key_bank.sv
module sim_round_key_bank;
    localparam int NP = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [127:0]       key_in = '0;
    logic [NP*4-1:0]    rd_idx = '0;
    logic [NP*128-1:0]  rd_key;
    logic               ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    round_key_bank #(.NPORTS(NP), .LATENCY(45)) u0 (
        .clk(clk), .rst(rst), .start(start), .key_in(key_in),
        .rd_idx(rd_idx), .rd_key(rd_key), .ready(ready)
    );

    localparam logic [127:0] KA    = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] KA_R1 = 128'ha0fafe1788542cb123a339392a6c7605;
    localparam logic [127:0] KA_R10= 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
    localparam logic [127:0] KZ_R1 = 128'h62636363626363636263636362636363;
    localparam logic [127:0] KZ_R10= 128'hb4ef5bcb3e92e21123e951cf6f8f188e;
    localparam logic [127:0] KC    = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] KC_R10= 128'h13111d7fe3944a17f307a78b4d2b30c5;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int p, input int idx, output logic [127:0] k);
        rd_idx[p*4 +: 4] = 4'(idx);
        #0.5;
        k = rd_key[p*128 +: 128];
    endtask

    // Pulse start; returns at the falling edge after the capturing edge
    task automatic pulse_start(input logic [127:0] k);
        @(negedge clk);
        start = 1'b1; key_in = k;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        logic [127:0] v;
        @(negedge clk);
        chk("R1 ready", {127'b0, ready}, 128'd0);
        for (int p = 0; p < NP; p++) begin
            rd(p, 0, v);
            chk("R1 port", v, 128'd0);
        end
    endtask

    task automatic t_expand(input logic [127:0] k, input logic [127:0] r1,
                            input logic [127:0] r10);
        logic [127:0] v;
        pulse_start(k);
        repeat (43) @(negedge clk);
        rd(0, 10, v);
        chk("R7 gated before ready", v, 128'd0);
        @(negedge clk);
        chk("R3 low at 44", {127'b0, ready}, 128'd0);
        @(negedge clk);
        chk("R3 high at 45", {127'b0, ready}, 128'd1);
        rd(0, 0, v);  chk("R2 round 0", v, k);
        rd(1, 1, v);  chk("R4 R5 round 1", v, r1);
        rd(2, 10, v); chk("R4 R5 round 10", v, r10);
    endtask

    task automatic t_ports();
        logic [127:0] a, b, c;
        rd_idx = {4'd10, 4'd1, 4'd0};
        #0.5;
        a = rd_key[0 +: 128]; b = rd_key[128 +: 128]; c = rd_key[256 +: 128];
        chk("R6 port0", a, KA);
        chk("R6 port1", b, KA_R1);
        chk("R6 port2", c, KA_R10);
    endtask

    task automatic t_range();
        logic [127:0] v;
        for (int i = 11; i < 16; i++) begin
            rd(i % NP, i, v);
            chk("R8 out of range", v, 128'd0);
        end
    endtask

    task automatic t_key_ignored();
        logic [127:0] v;
        @(negedge clk);
        key_in = ~KA;
        repeat (5) @(negedge clk);
        rd(0, 0, v);  chk("R10 round 0 held", v, KA);
        rd(1, 10, v); chk("R10 round 10 held", v, KA_R10);
        chk("R10 ready held", {127'b0, ready}, 128'd1);
    endtask

    task automatic t_restart();
        logic [127:0] v;
        pulse_start(128'h0);
        repeat (20) @(negedge clk);
        chk("R9 low mid-run", {127'b0, ready}, 128'd0);
        pulse_start(KC);
        repeat (44) @(negedge clk);
        chk("R9 low at 44 after restart", {127'b0, ready}, 128'd0);
        @(negedge clk);
        chk("R9 high at 45 after restart", {127'b0, ready}, 128'd1);
        rd(0, 0, v);  chk("R9 round 0 new key", v, KC);
        rd(1, 10, v); chk("R9 round 10 new key", v, KC_R10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_expand(KA, KA_R1, KA_R10);
        t_ports();
        t_range();
        t_key_ignored();
        t_expand(128'h0, KZ_R1, KZ_R10);
        t_restart();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule